// File: doc/BRIEF.md
# Microcontroller ALU with operand selection

This block is the 8-bit arithmetic and logic datapath of a small microcontroller that uses 12-bit instruction words. It is purely combinational. It picks two operands through a pair of 4-way selectors and applies one of nine operations to them. It then reports the 8-bit result, a zero indication and a carry-out. The instruction decoder, the register file, status storage, the program counter and the skip logic all sit outside this block. The block receives their values as plain inputs.

Two selector inputs do the work of dedicated hardware. On the A side, the fourth choice is a generated bit mask with one bit set, taken from a 3-bit bit number. The mask can be inverted. Setting a bit is then an OR with the plain mask, clearing a bit is an AND with the inverted mask, and testing a bit is an AND followed by a look at the zero output. On the B side, the fourth choice is the constant one, so increment and decrement reuse the adder. Rotates move through the incoming carry flag.

Top module: `mcu_alu_dp`

## Requirements
- R1: The A selector `a_sel_i` uses these codes: 0 for the working register, 1 for the file bus, 2 for the literal, and 3 for the bit mask.
- R2: The B selector `b_sel_i` uses these codes: 0 for the working register, 1 for the file bus, 2 for the literal, and 3 for the constant 0x01.
- R3: With `mask_invert_i`=0, the bit mask has only bit `bit_idx_i` set. With `mask_invert_i`=1, every bit of the mask is inverted.
- R4: Opcode 0000 gives the low 8 bits of A+B, and the carry-out is the ninth bit of the sum.
- R5: Opcode 1000 gives A-B modulo 256. The carry-out is 1 when A >= B unsigned, meaning no borrow, and 0 otherwise.
- R6: Opcodes 0001, 0010 and 0011 give A AND B, A OR B and A XOR B. The carry-out equals `carry_i`.
- R7: Opcode 0100 gives the bitwise inverse of A, and opcode 0111 gives A with its two nibbles exchanged. The carry-out equals `carry_i` for both.
- R8: Opcode 0101 gives {`carry_i`, A[7:1]}, with carry-out A[0].
- R9: Opcode 0110 gives {A[6:0], `carry_i`}, with carry-out A[7].
- R10: `zero_o` is 1 exactly when `result_o` is 0x00, whatever the opcode.
- R11: Opcodes 1001 through 1111 give a result of 0x00, and the carry-out equals `carry_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| w_reg_i | input | 8 | Working register value |
| file_bus_i | input | 8 | File-register read bus |
| literal_i | input | 8 | Literal field of the instruction |
| bit_idx_i | input | 3 | Bit number for the mask |
| mask_invert_i | input | 1 | 1 inverts the bit mask |
| a_sel_i | input | 2 | A operand source code |
| b_sel_i | input | 2 | B operand source code |
| op_i | input | 4 | Operation code |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 8 | Operation result |
| zero_o | output | 1 | Result-is-zero indication |
| carry_o | output | 1 | Carry-out |

## Verification
There is no register anywhere on the path, so all three outputs are due in the same cycle that the inputs change. The bench drives a new input set just after each rising edge. It compares result, zero and carry at the following falling edge, after the logic has settled and well before the next input change. Directed vectors with hand-computed values cover the carry, borrow, rotate and mask corners. A behavioural model written with integers then checks a long pseudo-random sweep, one comparison per clock.

// File: rtl/mcu_alu_pkg.sv
package mcu_alu_pkg;

  // Operation codes (values are part of the block's interface)
  typedef enum logic [3:0] {
    OP_ADD  = 4'b0000,
    OP_AND  = 4'b0001,
    OP_OR   = 4'b0010,
    OP_XOR  = 4'b0011,
    OP_COM  = 4'b0100,
    OP_ROR  = 4'b0101,
    OP_ROL  = 4'b0110,
    OP_SWAP = 4'b0111,
    OP_SUB  = 4'b1000
  } alu_op_e;

  // Operand source codes, shared by both selectors
  typedef enum logic [1:0] {
    SRC_WREG  = 2'b00,
    SRC_FILE  = 2'b01,
    SRC_LIT   = 2'b10,
    SRC_EXTRA = 2'b11
  } src_sel_e;

endpackage

// File: rtl/mcu_bitmask_gen.sv
module mcu_bitmask_gen #(
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              invert_i,
  output logic [DATA_W-1:0] mask_o
);

  logic [DATA_W-1:0] onehot_raw;

  // One comparator per bit position
  for (genvar gi = 0; gi < DATA_W; gi++) begin : g_bit
    assign onehot_raw[gi] = (idx_i == IDX_W'(gi));
  end

  assign mask_o = onehot_raw ^ {DATA_W{invert_i}};

  always_comb begin
    AST_MASK_ONE_SET: assert ($countones(onehot_raw) == 1); // R3
    if (!invert_i)
      AST_MASK_PLAIN: assert (mask_o[idx_i] && $countones(mask_o) == 1); // R3
    else
      AST_MASK_INVERTED: assert (!mask_o[idx_i] && $countones(mask_o) == DATA_W - 1); // R3
  end

endmodule

// File: rtl/mcu_operand_mux.sv
module mcu_operand_mux #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] wreg_i,
  input  logic [DATA_W-1:0] file_i,
  input  logic [DATA_W-1:0] lit_i,
  input  logic [DATA_W-1:0] extra_i,
  input  logic [1:0]        sel_i,
  output logic [DATA_W-1:0] opnd_o
);
  import mcu_alu_pkg::*;

  always_comb begin
    unique case (src_sel_e'(sel_i))
      SRC_WREG:  opnd_o = wreg_i;
      SRC_FILE:  opnd_o = file_i;
      SRC_LIT:   opnd_o = lit_i;
      default:   opnd_o = extra_i;
    endcase
  end

endmodule

// File: rtl/mcu_alu_core.sv
module mcu_alu_core #(
  parameter int DATA_W = 8,
  localparam int HALF_W = DATA_W / 2
) (
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic [3:0]        op_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_o,
  output logic              arith_o,
  output logic              rotate_o
);
  import mcu_alu_pkg::*;

  // {carry, sum}
  function automatic logic [DATA_W:0] f_add(input logic [DATA_W-1:0] a,
                                            input logic [DATA_W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  // {no_borrow, difference}: two's complement add of ~b plus one
  function automatic logic [DATA_W:0] f_sub(input logic [DATA_W-1:0] a,
                                            input logic [DATA_W-1:0] b);
    return {1'b0, a} + {1'b0, ~b} + {{DATA_W{1'b0}}, 1'b1};
  endfunction

  // {carry_out, rotated}
  function automatic logic [DATA_W:0] f_ror(input logic [DATA_W-1:0] a,
                                            input logic cin);
    return {a[0], cin, a[DATA_W-1:1]};
  endfunction

  function automatic logic [DATA_W:0] f_rol(input logic [DATA_W-1:0] a,
                                            input logic cin);
    return {a, cin};
  endfunction

  function automatic logic [DATA_W-1:0] f_swap(input logic [DATA_W-1:0] a);
    return {a[HALF_W-1:0], a[DATA_W-1:HALF_W]};
  endfunction

  logic [DATA_W:0] wide;

  always_comb begin
    arith_o  = 1'b0;
    rotate_o = 1'b0;
    wide     = {carry_i, {DATA_W{1'b0}}};
    case (alu_op_e'(op_i))
      OP_ADD:  begin wide = f_add(opa_i, opb_i); arith_o = 1'b1; end
      OP_SUB:  begin wide = f_sub(opa_i, opb_i); arith_o = 1'b1; end
      OP_AND:  wide = {carry_i, opa_i & opb_i};
      OP_OR:   wide = {carry_i, opa_i | opb_i};
      OP_XOR:  wide = {carry_i, opa_i ^ opb_i};
      OP_COM:  wide = {carry_i, ~opa_i};
      OP_SWAP: wide = {carry_i, f_swap(opa_i)};
      OP_ROR:  begin wide = f_ror(opa_i, carry_i); rotate_o = 1'b1; end
      OP_ROL:  begin wide = f_rol(opa_i, carry_i); rotate_o = 1'b1; end
      default: wide = {carry_i, {DATA_W{1'b0}}};
    endcase
  end

  assign result_o = wide[DATA_W-1:0];
  assign carry_o  = wide[DATA_W];

  always_comb begin
    if (!arith_o && !rotate_o)
      AST_CARRY_KEPT: assert (carry_o == carry_i); // R6
    if (op_i == OP_SUB)
      AST_SUB_NOBORROW: assert (carry_o == (opa_i >= opb_i)); // R5
    if (op_i == OP_ADD)
      AST_ADD_WRAP: assert (carry_o == (result_o < opa_i)); // R4
    if (op_i[3] && op_i != OP_SUB)
      AST_UNDEF_ZERO: assert (result_o == '0 && carry_o == carry_i); // R11
  end

endmodule

// File: rtl/mcu_alu_dp.sv
module mcu_alu_dp #(
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] w_reg_i,
  input  logic [DATA_W-1:0] file_bus_i,
  input  logic [DATA_W-1:0] literal_i,
  input  logic [IDX_W-1:0]  bit_idx_i,
  input  logic              mask_invert_i,
  input  logic [1:0]        a_sel_i,
  input  logic [1:0]        b_sel_i,
  input  logic [3:0]        op_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] result_o,
  output logic              zero_o,
  output logic              carry_o
);
  import mcu_alu_pkg::*;

  localparam logic [DATA_W-1:0] CONST_ONE = DATA_W'(1);

  logic [DATA_W-1:0] bit_mask;
  logic [DATA_W-1:0] opa;
  logic [DATA_W-1:0] opb;
  logic              arith_op;
  logic              rotate_op;

  mcu_bitmask_gen #(.DATA_W(DATA_W)) u_mask (
    .idx_i    (bit_idx_i),
    .invert_i (mask_invert_i),
    .mask_o   (bit_mask)
  );

  mcu_operand_mux #(.DATA_W(DATA_W)) u_mux_a (
    .wreg_i  (w_reg_i),
    .file_i  (file_bus_i),
    .lit_i   (literal_i),
    .extra_i (bit_mask),
    .sel_i   (a_sel_i),
    .opnd_o  (opa)
  );

  mcu_operand_mux #(.DATA_W(DATA_W)) u_mux_b (
    .wreg_i  (w_reg_i),
    .file_i  (file_bus_i),
    .lit_i   (literal_i),
    .extra_i (CONST_ONE),
    .sel_i   (b_sel_i),
    .opnd_o  (opb)
  );

  mcu_alu_core #(.DATA_W(DATA_W)) u_core (
    .opa_i    (opa),
    .opb_i    (opb),
    .op_i     (op_i),
    .carry_i  (carry_i),
    .result_o (result_o),
    .carry_o  (carry_o),
    .arith_o  (arith_op),
    .rotate_o (rotate_op)
  );

  assign zero_o = ~|result_o;

  always_comb begin
    AST_ZERO_FLAG: assert (zero_o == ($countones(result_o) == 0)); // R10
    if (b_sel_i == SRC_EXTRA)
      AST_B_CONST_ONE: assert (opb == CONST_ONE); // R2
    if (a_sel_i == SRC_FILE)
      AST_A_FILE: assert (opa == file_bus_i); // R1
    if (rotate_op && op_i == OP_ROR)
      AST_ROR_CARRY: assert (carry_o == opa[0] && result_o[DATA_W-1] == carry_i); // R8
    if (rotate_op && op_i == OP_ROL)
      AST_ROL_CARRY: assert (carry_o == opa[DATA_W-1] && result_o[0] == carry_i); // R9
    if (arith_op && b_sel_i == SRC_EXTRA && op_i == OP_ADD)
      AST_INC_STEP: assert (result_o == opa + CONST_ONE); // R4
  end

endmodule

// File: tb/mcu_alu_dp_bench.sv
module mcu_alu_dp_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] w_reg, file_bus, literal;
  logic [2:0] bit_idx;
  logic       mask_inv;
  logic [1:0] a_sel, b_sel;
  logic [3:0] op;
  logic       cin;
  logic [7:0] result;
  logic       zero, cout;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  mcu_alu_dp u_mcu_alu_dp (
    .w_reg_i       (w_reg),
    .file_bus_i    (file_bus),
    .literal_i     (literal),
    .bit_idx_i     (bit_idx),
    .mask_invert_i (mask_inv),
    .a_sel_i       (a_sel),
    .b_sel_i       (b_sel),
    .op_i          (op),
    .carry_i       (cin),
    .result_o      (result),
    .zero_o        (zero),
    .carry_o       (cout)
  );

  // Behavioural reference, integer arithmetic only
  function automatic void model(output int r, output int z, output int c);
    int a, b, m;
    m = 1 << int'(bit_idx);
    if (mask_inv) m = 255 - m;
    case (int'(a_sel))
      0: a = int'(w_reg);  1: a = int'(file_bus);
      2: a = int'(literal); default: a = m;
    endcase
    case (int'(b_sel))
      0: b = int'(w_reg);  1: b = int'(file_bus);
      2: b = int'(literal); default: b = 1;
    endcase
    c = int'(cin);
    case (int'(op))
      0: begin r = (a + b) % 256; c = (a + b > 255) ? 1 : 0; end
      8: begin r = (a - b + 256) % 256; c = (a >= b) ? 1 : 0; end
      1: r = a & b;
      2: r = a | b;
      3: r = a ^ b;
      4: r = 255 - a;
      5: begin r = a / 2 + c * 128; c = a % 2; end
      6: begin r = (a * 2) % 256 + c; c = a / 128; end
      7: r = (a % 16) * 16 + a / 16;
      default: r = 0;
    endcase
    z = (r == 0) ? 1 : 0;
  endfunction

  function automatic string req_of(input logic [3:0] o);
    case (int'(o))
      0: return "R4";  8: return "R5";
      1, 2, 3: return "R6";
      4, 7: return "R7";
      5: return "R8";  6: return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic compare(input string tag, input int er, input int ez, input int ec);
    total++;
    if (int'(result) != er || int'(zero) != ez || int'(cout) != ec) begin
      bad++;
      $display("FAIL %s: got r=%02h z=%0d c=%0d expected r=%02h z=%0d c=%0d",
               tag, result, zero, cout, er[7:0], ez, ec);
    end
  endtask

  task automatic drive(input logic [7:0] w, input logic [7:0] f, input logic [7:0] l,
                       input logic [2:0] idx, input logic inv, input logic [1:0] as,
                       input logic [1:0] bs, input logic [3:0] o, input logic ci);
    @(posedge clk);
    #1;
    w_reg = w; file_bus = f; literal = l; bit_idx = idx; mask_inv = inv;
    a_sel = as; b_sel = bs; op = o; cin = ci;
    @(negedge clk);
  endtask

  // Directed vector with hand-computed expectation
  task automatic vec(input string tag, input logic [7:0] w, input logic [7:0] f,
                     input logic [7:0] l, input logic [2:0] idx, input logic inv,
                     input logic [1:0] as, input logic [1:0] bs, input logic [3:0] o,
                     input logic ci, input int er, input int ec);
    drive(w, f, l, idx, inv, as, bs, o, ci);
    compare(tag, er, (er == 0) ? 1 : 0, ec);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      bad++;
      total++;
      $display("FAIL watchdog: got cycles=%0d expected below 200000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    w_reg = 0; file_bus = 0; literal = 0; bit_idx = 0; mask_inv = 0;
    a_sel = 0; b_sel = 0; op = 0; cin = 0;
    repeat (3) @(negedge clk);
    compare("R4 R10 reset state", 0, 1, 0);
    rst = 1'b0;

    // R1 A source selection (OR with B = literal)
    vec("R1 A=W",    8'h3C, 8'hA5, 8'h00, 3'd0, 1'b0, 2'd0, 2'd2, 4'b0010, 1'b0, 8'h3C, 0);
    vec("R1 A=file", 8'h3C, 8'hA5, 8'h00, 3'd0, 1'b0, 2'd1, 2'd2, 4'b0010, 1'b0, 8'hA5, 0);
    vec("R1 A=lit",  8'h3C, 8'hA5, 8'h5A, 3'd0, 1'b0, 2'd2, 2'd2, 4'b0010, 1'b1, 8'h5A, 1);
    vec("R1 A=mask", 8'h3C, 8'hA5, 8'h00, 3'd4, 1'b0, 2'd3, 2'd2, 4'b0010, 1'b0, 8'h10, 0);
    // R2 B source selection (AND with A = W = FF)
    vec("R2 B=W",    8'hFF, 8'h0F, 8'h33, 3'd0, 1'b0, 2'd0, 2'd0, 4'b0001, 1'b0, 8'hFF, 0);
    vec("R2 B=file", 8'hFF, 8'h0F, 8'h33, 3'd0, 1'b0, 2'd0, 2'd1, 4'b0001, 1'b0, 8'h0F, 0);
    vec("R2 B=lit",  8'hFF, 8'h0F, 8'h33, 3'd0, 1'b0, 2'd0, 2'd2, 4'b0001, 1'b0, 8'h33, 0);
    vec("R2 B=one",  8'h41, 8'h0F, 8'h33, 3'd0, 1'b0, 2'd0, 2'd3, 4'b0000, 1'b0, 8'h42, 0);
    // R3 bit mask: set, clear, test, and every position
    vec("R3 bit set",   8'h00, 8'h01, 8'h00, 3'd7, 1'b0, 2'd3, 2'd1, 4'b0010, 1'b0, 8'h81, 0);
    vec("R3 bit clear", 8'h00, 8'hFF, 8'h00, 3'd2, 1'b1, 2'd3, 2'd1, 4'b0001, 1'b0, 8'hFB, 0);
    vec("R3 R10 bit test", 8'h00, 8'hFE, 8'h00, 3'd0, 1'b0, 2'd3, 2'd1, 4'b0001, 1'b0, 8'h00, 0);
    for (int i = 0; i < 8; i++) begin
      vec("R3 mask position", 8'h00, 8'h00, 8'h00, 3'(i), 1'b0, 2'd3, 2'd1, 4'b0010, 1'b0, 1 << i, 0);
      vec("R3 inverted mask", 8'h00, 8'hFF, 8'h00, 3'(i), 1'b1, 2'd3, 2'd1, 4'b0001, 1'b1, 255 - (1 << i), 1);
    end
    // R4 add
    vec("R4 R10 add wrap", 8'hFF, 8'h00, 8'h00, 3'd0, 1'b0, 2'd0, 2'd3, 4'b0000, 1'b0, 8'h00, 1);
    vec("R4 add no carry", 8'h80, 8'h7F, 8'h00, 3'd0, 1'b0, 2'd0, 2'd1, 4'b0000, 1'b1, 8'hFF, 0);
    // R5 subtract A - B
    vec("R5 R10 sub equal", 8'h05, 8'h05, 8'h00, 3'd0, 1'b0, 2'd1, 2'd0, 4'b1000, 1'b0, 8'h00, 1);
    vec("R5 sub borrow",    8'h05, 8'h03, 8'h00, 3'd0, 1'b0, 2'd1, 2'd0, 4'b1000, 1'b1, 8'hFE, 0);
    vec("R5 decrement 0",   8'h00, 8'h00, 8'h00, 3'd0, 1'b0, 2'd1, 2'd3, 4'b1000, 1'b1, 8'hFF, 0);
    // R6 logic keeps carry
    vec("R6 R10 xor", 8'hAA, 8'h00, 8'hAA, 3'd0, 1'b0, 2'd0, 2'd2, 4'b0011, 1'b1, 8'h00, 1);
    // R7 complement and swap
    vec("R7 R10 com", 8'h00, 8'hFF, 8'h00, 3'd0, 1'b0, 2'd1, 2'd0, 4'b0100, 1'b1, 8'h00, 1);
    vec("R7 swap",    8'h00, 8'h3C, 8'h00, 3'd0, 1'b0, 2'd1, 2'd0, 4'b0111, 1'b0, 8'hC3, 0);
    // R8 rotate right through carry
    vec("R8 ror c in",  8'h00, 8'h01, 8'h00, 3'd0, 1'b0, 2'd1, 2'd0, 4'b0101, 1'b1, 8'h80, 1);
    vec("R8 ror plain", 8'h00, 8'h02, 8'h00, 3'd0, 1'b0, 2'd1, 2'd0, 4'b0101, 1'b0, 8'h01, 0);
    // R9 rotate left through carry
    vec("R9 R10 rol out", 8'h00, 8'h80, 8'h00, 3'd0, 1'b0, 2'd1, 2'd0, 4'b0110, 1'b0, 8'h00, 1);
    vec("R9 rol c in",    8'h00, 8'h40, 8'h00, 3'd0, 1'b0, 2'd1, 2'd0, 4'b0110, 1'b1, 8'h81, 0);
    // R11 undefined codes
    vec("R11 op 1011", 8'h12, 8'h77, 8'h34, 3'd0, 1'b0, 2'd1, 2'd0, 4'b1011, 1'b1, 8'h00, 1);
    vec("R11 op 1111", 8'h12, 8'h77, 8'h34, 3'd0, 1'b0, 2'd1, 2'd0, 4'b1111, 1'b0, 8'h00, 0);

    // Pseudo-random sweep, model compared every clock
    for (int n = 0; n < 3000; n++) begin
      int er, ez, ec;
      drive(8'($urandom), 8'($urandom), 8'($urandom), 3'($urandom), 1'($urandom),
            2'($urandom), 2'($urandom), 4'($urandom), 1'($urandom));
      model(er, ez, ec);
      compare({req_of(op), " R1 R2 R3 R10 sweep"}, er, ez, ec);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule